// File: doc/BRIEF.md
# Grouped Translation Buffer with Hashed Frame Codes

This block is a fully associative address translation buffer. Each entry covers an aligned group of virtually consecutive 4 KiB pages under one tag and one address-space identifier. For every page in the group the entry keeps a 7-bit frame code, not a full physical frame number. On a lookup the block matches the group tag and the ASID and picks the code of the addressed page. It then rebuilds the physical frame number from a fixed hash of the virtual page number. Physical memory is seen as an array of buckets with 64 slots each. Slots 0..55 of a bucket form its primary area, and slots 56..63 form its overflow area. A code names one of 104 candidate frames: a primary slot of one hashed bucket, or an overflow slot of one of six other hashed buckets.

A page walker installs a whole group at once through the fill port. Software-driven maintenance can clear one page, or it can drop every entry of one ASID on a context switch. The lookup result is registered and appears one cycle after the request.

Top module: `gtlb_top`

## Requirements
- R1: `rsp_valid` is high exactly one cycle after each cycle with `lk_req` high. On a hit, `rsp_pa[11:0]` equals the request's `lk_va[11:0]`.
- R2: The VPN is `lk_va[VA_W-1:12]`. Its upper `VPN_W-log2(GROUP)` bits are the group tag, and its low `log2(GROUP)` bits are the page index. A lookup hits only when an entry is valid, its ASID and tag both match, and the page's valid bit is set. Any other lookup gives `rsp_hit=0`, `rsp_fault=0` and `rsp_pa=0`.
- R3: The bucket hashes are defined as follows. `fold` is the XOR of the `BKT_W`-bit chunks of the VPN, taken from bit 0 upward. `hash_k = fold XOR low BKT_W bits of (k*0x2F5B)` for k = 0..6. The frame number is `bucket*64 + slot`.
- R4: A code c in 0..55 selects slot c of bucket `hash_0`.
- R5: A code c in 56..103 selects slot `56 + (c-56) mod 8` of bucket `hash_(1 + (c-56) div 8)`.
- R6: When a lookup finds a valid page whose code is 104..127, the response has `rsp_fault=1`, `rsp_hit=0` and `rsp_pa=0`.
- R7: A fill writes the ASID, the tag, the page-valid mask (bit i is page i) and all codes (page i at `fl_codes[7i+6:7i]`). When a valid entry with the same ASID and tag already exists, the fill rewrites that entry in place, so no two valid entries ever share an ASID and tag.
- R8: A fill that matches no entry takes the lowest-numbered invalid entry. When every entry is valid, it takes the entry named by a round-robin pointer. The pointer starts at 0 after reset and moves forward by one, modulo `ENTRIES`, on each such replacement.
- R9: A page invalidation clears only the valid bit of the addressed page, in the entry that matches its ASID and tag.
- R10: A flush by ASID invalidates every entry of that ASID and leaves the entries of all other ASIDs unchanged.
- R11: A lookup issued in the same cycle as a fill, an invalidation or a flush sees the contents from before that operation.
- R12: When more than one maintenance operation is requested in the same cycle, only the flush takes effect if it is present, otherwise only the invalidation. A fill takes effect only when it is alone.
- R13: After reset every entry is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup ASID |
| lk_va | input | VPN_W+12 | Lookup virtual address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Page present but code illegal |
| rsp_pa | output | BKT_W+18 | Physical address on hit, else zero |
| fl_en | input | 1 | Fill a whole group |
| fl_asid | input | ASID_W | Fill ASID |
| fl_tag | input | VPN_W-log2(GROUP) | Fill group tag |
| fl_pmask | input | GROUP | Per-page valid mask |
| fl_codes | input | 7*GROUP | Per-page frame codes |
| iv_en | input | 1 | Invalidate one page |
| iv_asid | input | ASID_W | Invalidation ASID |
| iv_vpn | input | VPN_W | Invalidation page number |
| fa_en | input | 1 | Flush one ASID |
| fa_asid | input | ASID_W | ASID to flush |

## Verification
A lookup can land in the same cycle as any maintenance operation. Maintenance operations can also collide with each other. The bench provokes both cases. It drives a lookup together with a fill or an invalidation of the same group, and it raises fill, invalidate and flush in pairs. The first response must show the old contents. Lookups made afterwards over every known group must show that only the winning operation changed the buffer.

// File: rtl/gtlb_pkg.sv
package gtlb_pkg;

    localparam int PG_OFS_W    = 12;
    localparam int CODE_W      = 7;
    localparam int SLOT_W      = 6;
    localparam int FRONT_SLOTS = 56;
    localparam int BACK_SLOTS  = 8;
    localparam int BACK_BKTS   = 6;
    localparam int LEGAL_LIMIT = FRONT_SLOTS + BACK_SLOTS * BACK_BKTS;
    localparam int HASH_CNT    = BACK_BKTS + 1;
    localparam logic [31:0] SALT_MUL = 32'h0000_2F5B;

    typedef enum logic [1:0] {
        CC_FRONT = 2'd0,
        CC_BACK  = 2'd1,
        CC_BAD   = 2'd2
    } code_cls_e;

    typedef struct packed {
        code_cls_e         cls;
        logic [2:0]        hsel;
        logic [SLOT_W-1:0] slot;
    } code_dec_t;

    function automatic code_dec_t decode_code(input logic [CODE_W-1:0] c);
        code_dec_t d;
        logic [5:0] r;
        d   = '0;
        r   = 6'(c - 7'(FRONT_SLOTS));
        d.cls = CC_BAD;
        if (c < 7'(FRONT_SLOTS)) begin
            d.cls  = CC_FRONT;
            d.hsel = 3'd0;
            d.slot = c[SLOT_W-1:0];
        end else if (c < 7'(LEGAL_LIMIT)) begin
            d.cls  = CC_BACK;
            d.hsel = r[5:3] + 3'd1;
            d.slot = 6'(FRONT_SLOTS) + {3'b000, r[2:0]};
        end
        return d;
    endfunction

    function automatic logic [31:0] bucket_salt(input int k);
        return 32'(k) * SALT_MUL;
    endfunction

endpackage

// File: rtl/gtlb_frame_expand.sv
module gtlb_frame_expand import gtlb_pkg::*; #(
    parameter int VPN_W = 20,
    parameter int BKT_W = 10,
    parameter int PFN_W = BKT_W + SLOT_W
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic [CODE_W-1:0] code,
    output logic [PFN_W-1:0]  pfn,
    output logic              illegal
);

    localparam int NCHUNK = (VPN_W + BKT_W - 1) / BKT_W;
    localparam int EXT_W  = NCHUNK * BKT_W;

    logic [EXT_W-1:0] vext;
    logic [BKT_W-1:0] fold;
    logic [BKT_W-1:0] bkt_hash [HASH_CNT];
    code_dec_t        dec;

    assign vext = EXT_W'(vpn);

    always_comb begin
        fold = '0;
        for (int i = 0; i < NCHUNK; i++) begin
            fold = fold ^ vext[i*BKT_W +: BKT_W];
        end
    end

    for (genvar k = 0; k < HASH_CNT; k++) begin : g_hash
        localparam logic [31:0] SALT_K = bucket_salt(k);
        assign bkt_hash[k] = fold ^ SALT_K[BKT_W-1:0];
    end

    assign dec     = decode_code(code);
    assign illegal = (dec.cls == CC_BAD);
    assign pfn     = {bkt_hash[dec.hsel], dec.slot};

    always_comb begin
        if (dec.cls == CC_FRONT) begin
            assert_front_slot_R4: assert (dec.slot < 6'(FRONT_SLOTS));
        end
    end

endmodule

// File: rtl/gtlb_victim_sel.sv
module gtlb_victim_sel #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic               advance,
    output logic [IDX_W-1:0]   victim,
    output logic               use_free
);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign use_free = ~&ent_valid;
    assign victim   = use_free ? free_idx : rr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (advance) begin
            if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
            else                               rr_ptr <= rr_ptr + 1'b1;
        end
    end

    assert_free_first_R8: assert property (@(posedge clk) disable iff (rst)
        use_free |-> !ent_valid[victim]);

    assert_advance_full_R8: assert property (@(posedge clk) disable iff (rst)
        advance |-> !use_free);

    assert_rr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (advance && rr_ptr == IDX_W'(ENTRIES - 1)) |=> (rr_ptr == '0));

endmodule

// File: rtl/gtlb_top.sv
module gtlb_top import gtlb_pkg::*; #(
    parameter int ENTRIES = 16,
    parameter int GROUP   = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int BKT_W   = 10,
    localparam int GIDX_W = $clog2(GROUP),
    localparam int TAG_W  = VPN_W - GIDX_W,
    localparam int PFN_W  = BKT_W + SLOT_W,
    localparam int VA_W   = VPN_W + PG_OFS_W,
    localparam int PA_W   = PFN_W + PG_OFS_W,
    localparam int CDS_W  = GROUP * CODE_W,
    localparam int EIDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    input  logic              fl_en,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [TAG_W-1:0]  fl_tag,
    input  logic [GROUP-1:0]  fl_pmask,
    input  logic [CDS_W-1:0]  fl_codes,
    input  logic              iv_en,
    input  logic [ASID_W-1:0] iv_asid,
    input  logic [VPN_W-1:0]  iv_vpn,
    input  logic              fa_en,
    input  logic [ASID_W-1:0] fa_asid
);

    // entry storage
    logic [ENTRIES-1:0] e_valid;
    logic [GROUP-1:0]   e_pmask [ENTRIES];
    logic [ASID_W-1:0]  e_asid  [ENTRIES];
    logic [TAG_W-1:0]   e_tag   [ENTRIES];
    logic [CDS_W-1:0]   e_codes [ENTRIES];

    // address fields
    logic [VPN_W-1:0]  lk_vpn;
    logic [TAG_W-1:0]  lk_tag;
    logic [GIDX_W-1:0] lk_page;
    logic [TAG_W-1:0]  iv_tag;
    logic [GIDX_W-1:0] iv_page;

    assign lk_vpn  = lk_va[VA_W-1:PG_OFS_W];
    assign lk_tag  = lk_vpn[VPN_W-1:GIDX_W];
    assign lk_page = lk_vpn[GIDX_W-1:0];
    assign iv_tag  = iv_vpn[VPN_W-1:GIDX_W];
    assign iv_page = iv_vpn[GIDX_W-1:0];

    // parallel tag compare
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic [ENTRIES-1:0] iv_match;
    logic [ENTRIES-1:0] fa_match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign lk_match[i] = e_valid[i] && (e_asid[i] == lk_asid) && (e_tag[i] == lk_tag);
        assign fl_match[i] = e_valid[i] && (e_asid[i] == fl_asid) && (e_tag[i] == fl_tag);
        assign iv_match[i] = e_valid[i] && (e_asid[i] == iv_asid) && (e_tag[i] == iv_tag);
        assign fa_match[i] = e_valid[i] && (e_asid[i] == fa_asid);
    end

    // lookup read path
    logic [GROUP-1:0]  sel_pmask;
    logic [CDS_W-1:0]  sel_codes;
    logic [CODE_W-1:0] sel_code;
    logic              sel_present;
    logic              tag_hit;
    logic [PFN_W-1:0]  exp_pfn;
    logic              exp_bad;

    always_comb begin
        sel_pmask = '0;
        sel_codes = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_pmask = sel_pmask | ({GROUP{lk_match[i]}} & e_pmask[i]);
            sel_codes = sel_codes | ({CDS_W{lk_match[i]}} & e_codes[i]);
        end
    end

    assign tag_hit     = |lk_match;
    assign sel_present = tag_hit && sel_pmask[lk_page];
    assign sel_code    = sel_codes[lk_page*CODE_W +: CODE_W];

    gtlb_frame_expand #(
        .VPN_W (VPN_W),
        .BKT_W (BKT_W),
        .PFN_W (PFN_W)
    ) u_expand (
        .vpn     (lk_vpn),
        .code    (sel_code),
        .pfn     (exp_pfn),
        .illegal (exp_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && sel_present && !exp_bad;
            rsp_fault <= lk_req && sel_present && exp_bad;
            rsp_pa    <= (lk_req && sel_present && !exp_bad) ?
                         {exp_pfn, lk_va[PG_OFS_W-1:0]} : '0;
        end
    end

    // fill placement
    logic [EIDX_W-1:0] fl_hit_idx;
    logic [EIDX_W-1:0] victim;
    logic [EIDX_W-1:0] fill_idx;
    logic              use_free;
    logic              fill_go;
    logic              rr_advance;

    always_comb begin
        fl_hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fl_match[i]) fl_hit_idx = EIDX_W'(i);
        end
    end

    assign fill_go    = fl_en && !fa_en && !iv_en;
    assign fill_idx   = (|fl_match) ? fl_hit_idx : victim;
    assign rr_advance = fill_go && !(|fl_match) && !use_free;

    gtlb_victim_sel #(
        .ENTRIES (ENTRIES),
        .IDX_W   (EIDX_W)
    ) u_victim (
        .clk       (clk),
        .rst       (rst),
        .ent_valid (e_valid),
        .advance   (rr_advance),
        .victim    (victim),
        .use_free  (use_free)
    );

    // state update, priority flush > invalidate > fill
    always_ff @(posedge clk) begin
        if (rst) begin
            e_valid <= '0;
            for (int i = 0; i < ENTRIES; i++) e_pmask[i] <= '0;
        end else if (fa_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fa_match[i]) e_valid[i] <= 1'b0;
            end
        end else if (iv_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (iv_match[i]) e_pmask[i][iv_page] <= 1'b0;
            end
        end else if (fl_en) begin
            e_valid[fill_idx] <= 1'b1;
            e_pmask[fill_idx] <= fl_pmask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && fill_go) begin
            e_asid[fill_idx]  <= fl_asid;
            e_tag[fill_idx]   <= fl_tag;
            e_codes[fill_idx] <= fl_codes;
        end
    end

    // checks
    assert_single_match_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);

    assert_no_rsp_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid);

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> (!rsp_hit || rsp_pa[PG_OFS_W-1:0] == $past(lk_va[PG_OFS_W-1:0])));

    assert_hit_fault_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_fault));

    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_pa == '0));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
        fa_en |=> !$past(fa_match) == !$past(fa_match) && ((e_valid & $past(fa_match)) == '0));

endmodule

// File: tb/gtlb_top_bench.sv
module gtlb_top_bench;

    localparam int E   = 4;
    localparam int G   = 8;
    localparam int VW  = 20;
    localparam int AW  = 4;
    localparam int BW  = 10;
    localparam int TW  = 17;
    localparam int VAW = 32;
    localparam int PAW = 28;
    localparam int CW  = 56;

    logic           clk = 1'b0;
    logic           rst;
    logic           lk_req;
    logic [AW-1:0]  lk_asid;
    logic [VAW-1:0] lk_va;
    logic           rsp_valid;
    logic           rsp_hit;
    logic           rsp_fault;
    logic [PAW-1:0] rsp_pa;
    logic           fl_en;
    logic [AW-1:0]  fl_asid;
    logic [TW-1:0]  fl_tag;
    logic [G-1:0]   fl_pmask;
    logic [CW-1:0]  fl_codes;
    logic           iv_en;
    logic [AW-1:0]  iv_asid;
    logic [VW-1:0]  iv_vpn;
    logic           fa_en;
    logic [AW-1:0]  fa_asid;

    always #5 clk = ~clk;

    gtlb_top #(
        .ENTRIES (E),
        .GROUP   (G),
        .VPN_W   (VW),
        .ASID_W  (AW),
        .BKT_W   (BW)
    ) u_gtlb_top (
        .clk(clk), .rst(rst),
        .lk_req(lk_req), .lk_asid(lk_asid), .lk_va(lk_va),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .fl_en(fl_en), .fl_asid(fl_asid), .fl_tag(fl_tag), .fl_pmask(fl_pmask), .fl_codes(fl_codes),
        .iv_en(iv_en), .iv_asid(iv_asid), .iv_vpn(iv_vpn),
        .fa_en(fa_en), .fa_asid(fa_asid)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string cur_lbl = "";

    // reference model of the buffer contents
    bit            m_v    [E];
    logic [AW-1:0] m_asid [E];
    logic [TW-1:0] m_tag  [E];
    logic [G-1:0]  m_pm   [E];
    logic [CW-1:0] m_cd   [E];
    int            m_rr;

    // groups ever installed, for full sweeps
    logic [TW-1:0] kn_tag  [64];
    logic [AW-1:0] kn_asid [64];
    int            kn_n = 0;

    function automatic int hash_k(input logic [VW-1:0] vpn, input int k);
        int f;
        f = int'(vpn[9:0] ^ vpn[19:10]);
        return (f ^ ((k * 32'h2F5B) & 1023)) & 1023;
    endfunction

    task automatic expect_lookup(input logic [AW-1:0] a, input logic [VAW-1:0] va,
                                 output bit eh, output bit ef, output logic [PAW-1:0] ep);
        logic [VW-1:0] vpn;
        int pg, c, bkt, slot, d;
        vpn = va[31:12];
        pg  = int'(vpn[2:0]);
        eh = 0; ef = 0; ep = '0;
        for (int i = 0; i < E; i++) begin
            if (m_v[i] && m_asid[i] == a && m_tag[i] == vpn[19:3] && m_pm[i][pg]) begin
                c = int'(m_cd[i][pg*7 +: 7]);
                if (c >= 104) begin
                    ef = 1;
                end else begin
                    eh = 1;
                    if (c < 56) begin
                        bkt = hash_k(vpn, 0); slot = c;
                    end else begin
                        d = c - 56;
                        bkt = hash_k(vpn, 1 + d / 8); slot = 56 + d % 8;
                    end
                    ep = {16'(bkt * 64 + slot), va[11:0]};
                end
            end
        end
    endtask

    task automatic model_update();
        int t;
        bit found;
        if (fa_en) begin
            for (int i = 0; i < E; i++) if (m_v[i] && m_asid[i] == fa_asid) m_v[i] = 0;
        end else if (iv_en) begin
            for (int i = 0; i < E; i++)
                if (m_v[i] && m_asid[i] == iv_asid && m_tag[i] == iv_vpn[19:3])
                    m_pm[i][iv_vpn[2:0]] = 1'b0;
        end else if (fl_en) begin
            found = 0; t = 0;
            for (int i = 0; i < E; i++)
                if (m_v[i] && m_asid[i] == fl_asid && m_tag[i] == fl_tag) begin found = 1; t = i; end
            if (!found) begin
                for (int i = E - 1; i >= 0; i--) if (!m_v[i]) begin found = 1; t = i; end
            end
            if (!found) begin t = m_rr; m_rr = (m_rr + 1) % E; end
            m_v[t] = 1; m_asid[t] = fl_asid; m_tag[t] = fl_tag;
            m_pm[t] = fl_pmask; m_cd[t] = fl_codes;
        end
    endtask

    task automatic clear_ctl();
        lk_req = 0; fl_en = 0; iv_en = 0; fa_en = 0;
    endtask

    task automatic set_lookup(input logic [AW-1:0] a, input logic [VAW-1:0] va, input string lbl);
        lk_req = 1; lk_asid = a; lk_va = va; cur_lbl = lbl;
    endtask

    task automatic set_fill(input logic [AW-1:0] a, input logic [TW-1:0] t,
                            input logic [G-1:0] pm, input logic [CW-1:0] cd);
        bit seen;
        fl_en = 1; fl_asid = a; fl_tag = t; fl_pmask = pm; fl_codes = cd;
        seen = 0;
        for (int i = 0; i < kn_n; i++) if (kn_tag[i] == t && kn_asid[i] == a) seen = 1;
        if (!seen && kn_n < 64) begin kn_tag[kn_n] = t; kn_asid[kn_n] = a; kn_n++; end
    endtask

    task automatic step();
        bit eh, ef, was_lk;
        logic [PAW-1:0] ep;
        was_lk = lk_req;
        eh = 0; ef = 0; ep = '0;
        if (was_lk) expect_lookup(lk_asid, lk_va, eh, ef, ep);
        @(negedge clk);
        if (was_lk) begin
            n_tests++;
            if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_fault !== ef || rsp_pa !== ep) begin
                n_fail++;
                $display("FAIL %s va=%h: got v=%b h=%b f=%b pa=%h exp v=1 h=%b f=%b pa=%h",
                         cur_lbl, lk_va, rsp_valid, rsp_hit, rsp_fault, rsp_pa, eh, ef, ep);
            end
        end
        model_update();
        clear_ctl();
    endtask

    task automatic check_all(input string lbl);
        for (int g = 0; g < kn_n; g++) begin
            for (int p = 0; p < G; p++) begin
                set_lookup(kn_asid[g], {kn_tag[g], 3'(p), 12'((g * 389 + p * 71) & 12'hFFF)}, lbl);
                step();
            end
        end
    endtask

    function automatic logic [CW-1:0] pack_codes(input int base, input int stride);
        logic [CW-1:0] v;
        v = '0;
        for (int p = 0; p < G; p++) v[p*7 +: 7] = 7'((base + p * stride) & 127);
        return v;
    endfunction

    initial begin
        rst = 1;
        clear_ctl();
        lk_asid = '0; lk_va = '0; fl_asid = '0; fl_tag = '0; fl_pmask = '0; fl_codes = '0;
        iv_asid = '0; iv_vpn = '0; fa_asid = '0;
        for (int i = 0; i < E; i++) begin
            m_v[i] = 0; m_asid[i] = '0; m_tag[i] = '0; m_pm[i] = '0; m_cd[i] = '0;
        end
        m_rr = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R13 / R1: idle gives no response, empty buffer misses
        step();
        n_tests++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 idle rsp_valid=%b exp 0", rsp_valid);
        end
        for (int k = 0; k < 6; k++) begin
            set_lookup(4'(k), 32'(k * 32'h0123_4567), "R13 empty after reset");
            step();
        end

        // sweep of all 128 codes over four rounds of full-buffer fills
        for (int r = 0; r < 4; r++) begin
            for (int e = 0; e < E; e++) begin
                set_fill(4'(1 + e % 2), 17'(r * 1000 + e * 37 + 5), 8'hFF, pack_codes(r * 32 + e * 8, 1));
                step();
            end
            check_all("R2 R3 R4 R5 R6 R8 code sweep");
            for (int e = 0; e < E; e++) begin
                set_lookup(4'(3 + e % 2), {17'(r * 1000 + e * 37 + 5), 3'(e), 12'h5A5}, "R2 asid mismatch");
                step();
            end
        end

        // R7: refill existing group in place with a partial mask
        set_fill(4'd1, 17'(3005), 8'hF0, pack_codes(0, 5));
        step();
        check_all("R7 refill in place");

        // R9: clear one page
        iv_en = 1; iv_asid = 4'd2; iv_vpn = {17'(3042), 3'd2};
        step();
        check_all("R9 page invalidate");

        // R10: flush asid 1
        fa_en = 1; fa_asid = 4'd1;
        step();
        check_all("R10 asid flush");

        // R8: two free entries used first, then round robin
        set_fill(4'd5, 17'(7001), 8'hFF, pack_codes(10, 3)); step();
        set_fill(4'd5, 17'(7002), 8'hFF, pack_codes(60, 1)); step();
        set_fill(4'd6, 17'(7003), 8'hFF, pack_codes(20, 2)); step();
        check_all("R8 free first then round robin");

        // R11: lookup in the same cycle as a fill of the same group
        set_lookup(4'd6, {17'(7003), 3'd1, 12'h777}, "R11 lookup with fill");
        set_fill(4'd6, 17'(7003), 8'hFF, pack_codes(70, 1));
        step();
        set_lookup(4'd6, {17'(7003), 3'd1, 12'h777}, "R11 after fill");
        step();
        set_lookup(4'd6, {17'(7003), 3'd4, 12'h001}, "R11 lookup with invalidate");
        iv_en = 1; iv_asid = 4'd6; iv_vpn = {17'(7003), 3'd4};
        step();
        set_lookup(4'd6, {17'(7003), 3'd4, 12'h001}, "R11 after invalidate");
        step();

        // R12: colliding maintenance
        set_fill(4'd7, 17'(8001), 8'hFF, pack_codes(1, 1));
        iv_en = 1; iv_asid = 4'd6; iv_vpn = {17'(7003), 3'd0};
        step();
        check_all("R12 invalidate beats fill");
        set_fill(4'd2, 17'(8002), 8'hFF, pack_codes(2, 1));
        fa_en = 1; fa_asid = 4'd5;
        iv_en = 1; iv_asid = 4'd6; iv_vpn = {17'(7003), 3'd3};
        step();
        check_all("R12 flush beats invalidate and fill");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule